// File: doc/BRIEF.md
# Maskable Prioritized Interrupt Request Logic

This block decides, every cycle, whether a small processor core should take an interrupt and which vector number to use. It serves eight request sources. Each source has a pending flag that a hardware trigger pulse sets and that software clears by writing to the block. Each source also has an arm bit and a three-bit priority level. Two global controls apply on top of those: a disable bit that blocks every source, and a threshold that blocks any level not below it.

A source is eligible only while four things hold together: its flag is set, it is armed, the global disable bit is clear, and its level passes the threshold test. Any flag that fails one of the other tests stays latched and is served as soon as the blocking condition goes away. Among eligible sources the block picks the most urgent one and reports it as `irq_number`. The core saves context, fetches the vector and nests interrupts outside this block.

Software reaches the registers through a single-cycle write port (`wr_en`, `wr_addr`, `wr_data`). There is no read path. The outputs are combinational from the block's registers, so a trigger or a register write that lands on one clock edge is visible on the outputs right after that edge.

Top module: `irq_qualifier`

## Requirements
- R1: A source whose arm bit is 0 never makes `irq_valid` high and is never reported, whatever its flag holds. Writing address 0 loads the arm bits, where bit i of `wr_data` is source i.
- R2: Bit i of `trig` high on a clock edge sets flag i. The flag then stays set until a write to address 1 with bit i of `wr_data` set clears it (write one to clear).
- R3: A write to address 2 loads the global disable bit from `wr_data[0]`. While that bit is 1, `irq_valid` is 0.
- R4: A write to address 3 loads the threshold from `wr_data[2:0]`. With a nonzero threshold, a source is eligible only if its level is strictly below the threshold. A threshold of 0 lets every level through.
- R5: A source is eligible when its flag, its arm bit, global enable and the level test are all true at once. A flag that fails any of them stays pending and is reported in the first cycle after the edge that makes all four true.
- R6: An eligible source whose flag is never cleared keeps `irq_valid` high on every cycle.
- R7: A write to address 8+i loads the level of source i from `wr_data[2:0]`. The lowest level value among eligible sources wins, and on equal levels the lowest source index wins.
- R8: A trigger and a clear of the same flag on the same edge leave the flag set.
- R9: While `irq_valid` is 1, `irq_number` equals 16 plus the winning index, so source 2 reports 18. While it is 0, `irq_number` is 0.
- R10: After reset all flags and arm bits are 0, all levels and the threshold are 0, the disable bit is 1, and `irq_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 8 | Per-source trigger pulses, one bit per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address: 0 arm, 1 clear, 2 disable, 3 threshold, 8+i level of source i |
| wr_data | input | 8 | Write data |
| irq_valid | output | 1 | An eligible request exists |
| irq_number | output | 8 | Vector number, 16 plus the winning source index, or 0 when idle |

## Verification
The bench drives a trigger and a clear of the same flag on the same edge. A design that gives the clear priority would drop that request for good. It leaves flags pending behind each of the disarm, disable and threshold gates in turn and then lifts the gate. A design that gated the flag itself, rather than the request, would never serve them. It puts the level exactly equal to the threshold, which an off-by-one compare would let through. It also sets up ties between equal levels, where a scan that prefers the highest index would report the wrong vector. A long random run follows, checked cycle by cycle against a behavioural model, and covers orderings that the directed cases miss.

// File: rtl/irq_qualifier.sv
module irq_qualifier #(
  parameter int NUM_SRC  = 8,
  parameter int PRIO_W   = 3,
  parameter int VEC_BASE = 16,
  parameter int NUM_W    = 8,
  localparam int IDX_W   = $clog2(NUM_SRC),
  localparam int ADDR_W  = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] trig,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [NUM_SRC-1:0] wr_data,
  output logic               irq_valid,
  output logic [NUM_W-1:0]   irq_number
);

  logic [NUM_SRC-1:0] arm_q, flag_q, eligible, clr_mask;
  logic               dis_q;
  logic [PRIO_W-1:0]  thr_q;
  logic [PRIO_W-1:0]  prio_q [NUM_SRC];

  wire wr_arm  = wr_en && wr_addr == ADDR_W'(0);
  wire wr_clr  = wr_en && wr_addr == ADDR_W'(1);
  wire wr_dis  = wr_en && wr_addr == ADDR_W'(2);
  wire wr_thr  = wr_en && wr_addr == ADDR_W'(3);
  wire wr_prio = wr_en && wr_addr[ADDR_W-1];

  assign clr_mask = wr_clr ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q  <= '0;
      flag_q <= '0;
      dis_q  <= 1'b1;
      thr_q  <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_mask) | trig;
      if (wr_arm) arm_q <= wr_data;
      if (wr_dis) dis_q <= wr_data[0];
      if (wr_thr) thr_q <= wr_data[PRIO_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)
        prio_q[i] <= '0;
      else if (wr_prio && wr_addr[IDX_W-1:0] == IDX_W'(i))
        prio_q[i] <= wr_data[PRIO_W-1:0];
    end
    assign eligible[i] = flag_q[i] && arm_q[i] && !dis_q &&
                         (thr_q == '0 || prio_q[i] < thr_q);
  end

  logic              found;
  logic [IDX_W-1:0]  best_i;
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    found  = 1'b0;
    best_i = '0;
    best_p = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && (!found || prio_q[i] < best_p)) begin
        found  = 1'b1;
        best_i = IDX_W'(i);
        best_p = prio_q[i];
      end
    end
  end

  assign irq_valid  = found;
  assign irq_number = found ? NUM_W'(VEC_BASE) + NUM_W'(best_i) : '0;

  logic [IDX_W-1:0] out_idx;
  assign out_idx = IDX_W'(irq_number - NUM_W'(VEC_BASE));

  AST_ARMED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> arm_q[out_idx]);  // R1
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(flag_q & ~clr_mask)) == $past(flag_q & ~clr_mask)));  // R2
  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |-> !irq_valid);  // R3
  AST_LEVEL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && thr_q != '0) |-> prio_q[out_idx] < thr_q);  // R4
  AST_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> flag_q[out_idx]);  // R5
  AST_TRIG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig) |=> ((flag_q & $past(trig)) == $past(trig)));  // R8
  AST_IDLE_NUMBER: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> irq_number == '0);  // R9
  AST_NUMBER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_number >= NUM_W'(VEC_BASE) &&
                   irq_number < NUM_W'(VEC_BASE + NUM_SRC)));  // R9

endmodule

// File: tb/irq_qualifier_test.sv
`timescale 1ns/1ps
module irq_qualifier_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] trig = '0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       irq_valid;
  logic [7:0] irq_number;

  irq_qualifier uut (.clk(clk), .rst_n(rst_n), .trig(trig), .wr_en(wr_en),
                     .wr_addr(wr_addr), .wr_data(wr_data),
                     .irq_valid(irq_valid), .irq_number(irq_number));

  always #2 clk = ~clk;

  int vectors = 0, fails = 0;
  bit done = 0;
  string cur_req = "R10";

  bit m_flag[8], m_arm[8], m_dis;
  int m_prio[8], m_thr;

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      m_flag[i] = 0; m_arm[i] = 0; m_prio[i] = 0;
    end
    m_dis = 1; m_thr = 0;
  endtask

  task automatic model_edge();
    if (!rst_n) begin model_reset(); return; end
    if (wr_en) begin
      if (wr_addr == 0) for (int i = 0; i < 8; i++) m_arm[i] = wr_data[i];
      else if (wr_addr == 1) begin
        for (int i = 0; i < 8; i++) if (wr_data[i]) m_flag[i] = 0;
      end
      else if (wr_addr == 2) m_dis = wr_data[0];
      else if (wr_addr == 3) m_thr = wr_data[2:0];
      else if (wr_addr >= 8) m_prio[wr_addr - 8] = wr_data[2:0];
    end
    for (int i = 0; i < 8; i++) if (trig[i]) m_flag[i] = 1;
  endtask

  task automatic compare();
    int best = 99, idx = -1, exp_n;
    bit exp_v;
    for (int i = 0; i < 8; i++)
      if (m_flag[i] && m_arm[i] && !m_dis && (m_thr == 0 || m_prio[i] < m_thr)
          && m_prio[i] < best) begin
        best = m_prio[i]; idx = i;
      end
    exp_v = (idx >= 0);
    exp_n = exp_v ? 16 + idx : 0;
    vectors++;
    if (irq_valid !== exp_v || irq_number !== 8'(exp_n)) begin
      fails++;
      $display("FAIL %s: valid=%0b number=%0d, expected valid=%0b number=%0d",
               cur_req, irq_valid, irq_number, exp_v, exp_n);
    end
  endtask

  task automatic step(input logic [7:0] t, input bit we, input int a, input int d);
    @(negedge clk);
    compare();
    trig = t; wr_en = we; wr_addr = 4'(a); wr_data = 8'(d);
    @(posedge clk);
    model_edge();
  endtask

  task automatic wr(input int a, input int d);
    step(8'h00, 1, a, d);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(8'h00, 0, 0, 0);
  endtask

  initial begin
    model_reset();
    cur_req = "R10";
    for (int k = 0; k < 3; k++) step(8'hFF, 1, 0, 8'hFF);
    @(negedge clk); rst_n = 1'b1; trig = '0; wr_en = 0;
    @(posedge clk); model_edge();
    idle(2);

    cur_req = "R1";
    wr(2, 0);
    step(8'h08, 0, 0, 0);
    idle(3);
    cur_req = "R5";
    wr(0, 8'h08);
    idle(1);
    cur_req = "R9";
    idle(1);
    cur_req = "R6";
    idle(4);
    cur_req = "R2";
    wr(1, 8'h08);
    idle(2);

    cur_req = "R3";
    wr(2, 1);
    step(8'h04, 0, 0, 0);
    wr(0, 8'h0C);
    idle(3);
    wr(2, 0);
    idle(2);
    wr(1, 8'hFF);

    cur_req = "R4";
    wr(13, 4);
    wr(0, 8'h20);
    wr(3, 4);
    step(8'h20, 0, 0, 0);
    idle(2);
    wr(3, 5);
    idle(2);
    wr(3, 0);
    idle(2);
    wr(13, 7);
    wr(3, 7);
    idle(2);
    wr(1, 8'hFF);
    wr(3, 0);

    cur_req = "R7";
    wr(0, 8'hFF);
    for (int i = 0; i < 8; i++) wr(8 + i, 7 - i);
    step(8'hFF, 0, 0, 0);
    for (int i = 7; i >= 0; i--) wr(1, 1 << i);
    for (int i = 0; i < 8; i++) wr(8 + i, 2);
    step(8'hA4, 0, 0, 0);
    wr(1, 8'h04);
    wr(1, 8'h20);
    wr(1, 8'h80);

    cur_req = "R8";
    step(8'h02, 0, 0, 0);
    step(8'h02, 1, 1, 8'h02);
    idle(2);
    wr(1, 8'h02);
    idle(1);

    cur_req = "R7";
    for (int k = 0; k < 3000; k++) begin
      int sel = $urandom % 16;
      logic [7:0] t = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      if (sel < 8) step(t, 0, 0, 0);
      else if (sel < 10) step(t, 1, 1, $urandom);
      else if (sel == 10) step(t, 1, 0, $urandom);
      else if (sel == 11) step(t, 1, 2, ($urandom % 4 == 0));
      else if (sel == 12) step(t, 1, 3, $urandom % 8);
      else step(t, 1, 8 + $urandom % 8, $urandom % 8);
    end
    @(negedge clk);
    compare();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule